// File: doc/BRIEF.md
# Bandwidth-Throttled Memory Target With Retry

This block is a word-addressed storage target serving a single requester. Each request carries an operation code, a byte address, write data with byte enables, a transfer size in bytes, a flag saying whether a response is wanted, and a flag saying that some other agent will supply the data instead. The block decides in the same cycle whether it takes the request. After every read or write it takes, it holds itself busy for a number of cycles equal to the transfer size times a per-byte cost. That caps the short-term data rate.

A request refused while the block is busy, or while its response queue is full, leaves the block owing the requester one retry. Once the block can take work again it pays that debt with a single-cycle retry pulse. Until the pulse, every ordinary request is refused and leaves no trace. Responses wait in a small queue, each stamped with a due cycle. The due cycle is the base latency plus a pseudo-random extra of at most a configured bound. Responses leave the queue in the order their requests were taken.

The request channel works like a valid/ready channel, with one difference. `req_ready` is computed from the current request fields and the block state, whatever `req_valid` is, and a request is taken in any cycle where both are high. A refused request need not be held: the requester may drop it and offer it again at or after the retry pulse. The response channel is standard valid/ready. While `rsp_valid` is high and `rsp_ready` is low, the response stays on the pins unchanged.

Top module: `tmem_target`

## Requirements
- R1: A request with `req_inhibit` high is always taken (`req_ready` high), whatever the busy, owed or queue state. It does not change the storage, does not start a busy window and never produces a response.
- R2: While a retry is owed, any request with `req_inhibit` low is refused. The refusal changes no storage, busy window or queue contents, and this holds even after the busy window has ended, until the retry pulse.
- R3: If no retry is owed, a request with `req_inhibit` low is refused in either of two cases: the block is busy, or `req_need_rsp` is high and the queue holds 4 entries. The refusal makes a retry owed.
- R4: An accepted read (`req_op`=0) or write (`req_op`=1) taken in cycle t with duration D = `req_size`×`cfg_byte_cost` keeps the block busy in cycles t+1 to t+D. For a probe with `req_need_rsp` and `req_inhibit` low, `req_ready` is then low in exactly those cycles. Op codes 2 and 3 never start a busy window.
- R5: When D is zero, the block never becomes busy, and `req_ready` stays high in the following cycle.
- R6: An accepted write updates the storage in the cycle it is taken. Byte lane i (data bits 8i+7 to 8i) changes only when `req_be[i]` is high. A read returns the whole word selected by `req_addr[5:2]`, and `req_addr[1:0]` is ignored. The storage resets to zero.
- R7: A response to a request taken in cycle t first appears no earlier than cycle t+1+L. It appears no later than cycle t+1+L+V when the queue was empty. L is `cfg_base_lat` and V is `cfg_lat_var`, and the extra delay varies between requests. With V=0 the response appears in exactly cycle t+1+L.
- R8: A retry pulse comes one cycle after the first cycle in which a retry is owed, the block is not busy and the queue is not full. It lasts one cycle and is the only pulse for that debt. A request offered in the pulse cycle can be taken. Without a refusal there is no pulse.
- R9: A taken request with `req_need_rsp` low produces no response.
- R10: Responses leave in the order their requests were taken. `rsp_op` echoes the op code. `rsp_data` is the read word for reads and zero for the other ops. A response held by `rsp_ready` low keeps its data until it is taken.
- R11: After reset, the block is not busy, owes no retry, has an empty queue, drives `rsp_valid` and `retry_pulse` low, and drives `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base_lat | input | 8 | Base response latency in cycles |
| cfg_lat_var | input | 8 | Upper bound of the random extra latency |
| cfg_byte_cost | input | 4 | Busy cycles per transferred byte |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request would be taken this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 and 3 other commands |
| req_inhibit | input | 1 | Another agent supplies the data; take and drop |
| req_need_rsp | input | 1 | Request wants a response |
| req_addr | input | 6 | Byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Write byte enables |
| req_size | input | 4 | Transfer size in bytes |
| retry_pulse | output | 1 | One-cycle notice that a refused requester may try again |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_op | output | 2 | Op code of the answered request |
| rsp_data | output | 32 | Read data, zero for other ops |

## Verification
Several properties are checked on every cycle. The busy counter counts down by one per cycle. A retry pulse lasts one cycle and only comes once the block is idle. A request offered while a retry is owed never writes, queues or loads a busy window. An inhibited request is always taken without effect, nothing is pushed into a full queue, a stalled response keeps its data, and the random extra never exceeds its bound. Other behaviour only the bench scenarios can show: the exact length of each busy window over a sweep of sizes and costs, the exact response cycle over a sweep of base latencies, the range and variation of the random delay, byte-lane merging in storage, the cycle of the retry pulse relative to the end of the window, and that refused requests leave the stored data unchanged.

// File: rtl/tmem_pkg.sv
package tmem_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_FLUSH = 2'd2,
    OP_NOP   = 2'd3
  } tmem_op_e;

  function automatic logic op_moves_data(input logic [1:0] op);
    return (op == OP_READ) || (op == OP_WRITE);
  endfunction

endpackage

// File: rtl/tmem_store.sv
module tmem_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [DATA_W/8-1:0]   be_i,
  output logic [DATA_W-1:0]     rdata_o
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int IDX_W = ADDR_W - OFF_W;
  localparam int WORDS = 1 << IDX_W;

  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] unused_offset;

  assign idx           = addr_i[ADDR_W-1:OFF_W];
  assign unused_offset = addr_i[OFF_W-1:0];

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [7:0] lane_q [WORDS];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int w = 0; w < WORDS; w++) lane_q[w] <= 8'h00;
      end else if (we_i && be_i[b]) begin
        lane_q[idx] <= wdata_i[8*b +: 8];
      end
    end

    assign rdata_o[8*b +: 8] = lane_q[idx];
  end

endmodule

// File: rtl/tmem_lfsr.sv
module tmem_lfsr #(
  parameter int              W     = 16,
  parameter int              OUT_W = 8,
  parameter logic [W-1:0]    TAPS  = 16'hB400,
  parameter logic [W-1:0]    SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OUT_W-1:0] bound_i,
  output logic [OUT_W-1:0] rand_o
);
  localparam int PROD_W = 2 * OUT_W + 1;

  logic [W-1:0]      state_q;
  logic [PROD_W-1:0] prod;
  logic [OUT_W:0]    span;
  logic              unused_prod;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
  end

  // scale an OUT_W-bit sample into 0..bound by multiply and shift
  assign span        = {1'b0, bound_i} + 1'b1;
  assign prod        = PROD_W'(state_q[OUT_W-1:0]) * PROD_W'(span);
  assign rand_o      = prod[2*OUT_W-1:OUT_W];
  assign unused_prod = ^{prod[PROD_W-1], prod[OUT_W-1:0]};

  AST_RAND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rand_o <= bound_i); // R7

endmodule

// File: rtl/tmem_busy_ctrl.sv
module tmem_busy_ctrl #(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic             refuse_i,
  input  logic             full_i,
  output logic             busy_o,
  output logic             owed_o,
  output logic             retry_o
);
  logic [DUR_W-1:0] cnt_q;
  logic             owed_q;
  logic             retry_q;
  logic             settle;

  assign settle = owed_q && (cnt_q == '0) && !full_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= dur_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed_q  <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      retry_q <= settle;
      if (refuse_i)    owed_q <= 1'b1;
      else if (settle) owed_q <= 1'b0;
    end
  end

  assign busy_o  = (cnt_q != '0);
  assign owed_o  = owed_q;
  assign retry_o = retry_q;

  AST_BUSY_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !load_i) |=> cnt_q == $past(cnt_q) - 1'b1); // R4
  AST_RETRY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    retry_q |=> !retry_q); // R8
  AST_RETRY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    retry_q |-> (cnt_q == '0) && !owed_q); // R8

endmodule

// File: rtl/tmem_rsp_queue.sv
module tmem_rsp_queue #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  parameter int DLY_W  = 9,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [1:0]        push_op_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [DLY_W-1:0]  push_dly_i,
  input  logic              pop_ready_i,
  output logic              valid_o,
  output logic [1:0]        op_o,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TIME_W-1:0] now_q;
  logic [TIME_W-1:0] due_q  [DEPTH];
  logic [1:0]        op_q   [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt_q;
  logic [TIME_W-1:0] head_age;
  logic              pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push_i) begin
      due_q[wr_ptr]  <= now_q + TIME_W'(push_dly_i) + 1'b1;
      op_q[wr_ptr]   <= push_op_i;
      data_q[wr_ptr] <= push_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wr_ptr <= bump(wr_ptr);
      if (pop)    rd_ptr <= bump(rd_ptr);
      case ({push_i, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // head is due once now has reached its stamp (wrap-safe compare)
  assign head_age = now_q - due_q[rd_ptr];
  assign valid_o  = (cnt_q != '0) && !head_age[TIME_W-1];
  assign pop      = valid_o && pop_ready_i;
  assign op_o     = op_q[rd_ptr];
  assign data_o   = data_q[rd_ptr];
  assign full_o   = (cnt_q == CNT_W'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o); // R3
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !pop_ready_i) |=> valid_o && $stable(data_o) && $stable(op_o)); // R10

endmodule

// File: rtl/tmem_target.sv
module tmem_target #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 4,
  parameter int COST_W = 4,
  parameter int LAT_W  = 8,
  parameter int DEPTH  = 4,
  parameter int TIME_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LAT_W-1:0]    cfg_base_lat,
  input  logic [LAT_W-1:0]    cfg_lat_var,
  input  logic [COST_W-1:0]   cfg_byte_cost,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_op,
  input  logic                req_inhibit,
  input  logic                req_need_rsp,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic [SIZE_W-1:0]   req_size,
  output logic                retry_pulse,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [1:0]          rsp_op,
  output logic [DATA_W-1:0]   rsp_data
);
  import tmem_pkg::*;

  localparam int DUR_W = SIZE_W + COST_W;
  localparam int DLY_W = LAT_W + 1;

  logic              busy, owed, q_full;
  logic              blocked, taken, fire;
  logic              store_we, busy_load, q_push, refuse;
  logic [DUR_W-1:0]  dur;
  logic [DATA_W-1:0] rdata;
  logic [LAT_W-1:0]  rnd;
  logic [DLY_W-1:0]  dly;

  assign dur     = DUR_W'(req_size) * DUR_W'(cfg_byte_cost);
  assign blocked = busy || (req_need_rsp && q_full);

  assign req_ready = req_inhibit || (!owed && !blocked);
  assign taken     = req_valid && req_ready;
  assign fire      = taken && !req_inhibit;
  assign store_we  = fire && (req_op == OP_WRITE);
  assign busy_load = fire && op_moves_data(req_op) && (dur != '0);
  assign q_push    = fire && req_need_rsp;
  assign refuse    = req_valid && !req_inhibit && !owed && blocked;
  assign dly       = DLY_W'(cfg_base_lat) + DLY_W'(rnd);

  tmem_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (store_we),
    .addr_i  (req_addr),
    .wdata_i (req_wdata),
    .be_i    (req_be),
    .rdata_o (rdata)
  );

  tmem_busy_ctrl #(.DUR_W(DUR_W)) u_busy (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (busy_load),
    .dur_i    (dur),
    .refuse_i (refuse),
    .full_i   (q_full),
    .busy_o   (busy),
    .owed_o   (owed),
    .retry_o  (retry_pulse)
  );

  tmem_lfsr #(.W(16), .OUT_W(LAT_W)) u_rng (
    .clk     (clk),
    .rst_n   (rst_n),
    .bound_i (cfg_lat_var),
    .rand_o  (rnd)
  );

  tmem_rsp_queue #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .DLY_W(DLY_W), .TIME_W(TIME_W)
  ) u_queue (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (q_push),
    .push_op_i   (req_op),
    .push_data_i ((req_op == OP_READ) ? rdata : '0),
    .push_dly_i  (dly),
    .pop_ready_i (rsp_ready),
    .valid_o     (rsp_valid),
    .op_o        (rsp_op),
    .data_o      (rsp_data),
    .full_o      (q_full)
  );

  AST_OWED_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (owed && req_valid && !req_inhibit) |-> !store_we && !q_push && !busy_load); // R2
  AST_INHIBIT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_inhibit) |-> req_ready && !store_we && !q_push && !busy_load); // R1
  AST_ZERO_DUR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dur == '0 && !busy) |=> !busy); // R5

endmodule

// File: tb/tmem_target_tb.sv
`timescale 1ns/1ps
module tmem_target_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_base_lat = '0, cfg_lat_var = '0;
  logic [3:0]  cfg_byte_cost = '0;
  logic        req_valid = 0, req_inhibit = 0, req_need_rsp = 0;
  logic [1:0]  req_op = '0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0, req_size = '0;
  logic        req_ready, retry_pulse, rsp_valid, rsp_ready = 1'b1;
  logic [1:0]  rsp_op;
  logic [31:0] rsp_data;

  int checks = 0, fails = 0, retry_cnt = 0;
  logic [31:0] model [16];

  always #4 clk = ~clk;
  always @(posedge clk) if (rst_n && retry_pulse) retry_cnt <= retry_cnt + 1;

  tmem_target u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_base_lat(cfg_base_lat), .cfg_lat_var(cfg_lat_var),
    .cfg_byte_cost(cfg_byte_cost), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_inhibit(req_inhibit), .req_need_rsp(req_need_rsp),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_size(req_size),
    .retry_pulse(retry_pulse), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_op(rsp_op), .rsp_data(rsp_data)
  );

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] op, input logic [5:0] addr, input logic [31:0] d,
                       input logic [3:0] be, input logic [3:0] size, input logic need,
                       input logic inh, output logic acc);
    req_valid = 1; req_op = op; req_addr = addr; req_wdata = d; req_be = be;
    req_size = size; req_need_rsp = need; req_inhibit = inh;
    #1 acc = req_ready;
    if (acc && !inh && op == 2'd1)
      for (int b = 0; b < 4; b++) if (be[b]) model[addr[5:2]][8*b +: 8] = d[8*b +: 8];
    tick();
    req_valid = 0; req_need_rsp = 0; req_inhibit = 0;
  endtask

  task automatic do_read(input logic [5:0] addr, output logic [31:0] d, output int lat);
    logic acc;
    issue(2'd0, addr, '0, '0, 4'd4, 1'b1, 1'b0, acc);
    check(acc, "R6 read taken", acc, 1);
    lat = 1;
    while (!rsp_valid && lat < 600) begin tick(); lat++; end
    d = rsp_data;
    check(rsp_op == 2'd0, "R10 read op echo", rsp_op, 0);
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic acc;
    logic [31:0] d;
    int lat, base, n, lo, hi;
    for (int w = 0; w < 16; w++) model[w] = '0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R11 reset state
    check(req_ready == 1, "R11 ready after reset", req_ready, 1);
    check(rsp_valid == 0, "R11 no response after reset", rsp_valid, 0);
    check(retry_pulse == 0, "R11 no retry after reset", retry_pulse, 0);
    do_read(6'd20, d, lat);
    check(d == 0, "R11 storage zero", d, 0);

    // R6 byte lanes and word select, R7 L=0 exact
    issue(2'd1, 6'd4, 32'h11223344, 4'hF, 4'd4, 0, 0, acc);
    issue(2'd1, 6'd4, 32'hAABBCCDD, 4'h5, 4'd4, 0, 0, acc);
    do_read(6'd6, d, lat);
    check(d == 32'h11BB33DD, "R6 byte enable merge", d, 32'h11BB33DD);
    check(lat == 1, "R7 zero latency", lat, 1);
    for (int w = 0; w < 16; w++)
      issue(2'd1, 6'(w*4), 32'h0102_0304 * (w + 1) ^ 32'hA5A5_0000, 4'(w + 1), 4'd4, 0, 0, acc);
    for (int w = 0; w < 16; w++) begin
      do_read(6'(w*4 + (w % 4)), d, lat);
      check(d == model[w], "R6 word sweep", d, model[w]);
    end

    // R7 exact latency sweep with no variation
    for (int l = 0; l < 7; l++) begin
      cfg_base_lat = 8'(l);
      do_read(6'd8, d, lat);
      check(lat == l + 1, "R7 base latency", lat, l + 1);
    end

    // R7 random extra bounded and varying
    cfg_base_lat = 8'd2; cfg_lat_var = 8'd3; lo = 99; hi = 0;
    for (int i = 0; i < 40; i++) begin
      do_read(6'd12, d, lat);
      check(lat >= 3 && lat <= 6, "R7 latency range", lat, 3);
      check(d == model[3], "R7 data with random delay", d, model[3]);
      if (lat < lo) lo = lat;
      if (lat > hi) hi = lat;
    end
    check(hi > lo, "R7 extra delay varies", hi, lo + 1);
    cfg_base_lat = 0; cfg_lat_var = 0;

    // R4/R5 busy window sweep
    base = retry_cnt;
    for (int c = 0; c < 4; c++)
      for (int s = 1; s < 5; s++) begin
        cfg_byte_cost = 4'(c);
        issue(2'd1, 6'd60, model[15], 4'h0, 4'(s), 0, 0, acc);
        n = 0;
        while (!req_ready && n < 300) begin n++; tick(); end
        check(n == s * c, (c == 0) ? "R5 zero duration" : "R4 busy length", n, s * c);
      end
    cfg_byte_cost = 4'd3;
    issue(2'd2, 6'd0, '0, '0, 4'd4, 0, 0, acc);
    check(req_ready == 1, "R4 other op never busy", req_ready, 1);
    issue(2'd2, 6'd0, '0, '0, 4'd4, 1, 0, acc);
    check(rsp_valid && rsp_op == 2'd2 && rsp_data == 0, "R10 other op response", rsp_op, 2);
    tick();
    check(retry_cnt == base, "R8 no pulse without refusal", retry_cnt, base);

    // R3/R2/R8 refusal, owed and pulse timing (D = 2*3 = 6)
    issue(2'd1, 6'd32, model[8], 4'h0, 4'd2, 0, 0, acc);  // cycle t
    tick();                                                // t+2
    issue(2'd1, 6'd32, 32'hDEAD0001, 4'hF, 4'd4, 0, 0, acc);
    check(acc == 0, "R3 refused while busy", acc, 0);
    issue(2'd1, 6'd32, 32'hDEAD0002, 4'hF, 4'd4, 0, 0, acc);
    check(acc == 0, "R2 refused while owed", acc, 0);
    repeat (3) tick();                                     // t+7
    check(req_ready == 0 && retry_pulse == 0, "R2 owed holds after window", req_ready, 0);
    tick();                                                // t+8
    check(retry_pulse == 1, "R8 pulse cycle", retry_pulse, 1);
    issue(2'd3, 6'd0, '0, '0, 4'd1, 0, 0, acc);
    check(acc == 1, "R8 taken in pulse cycle", acc, 1);
    check(retry_pulse == 0, "R8 pulse one cycle", retry_pulse, 1'b0);
    cfg_byte_cost = 0;
    do_read(6'd32, d, lat);
    check(d == model[8], "R2 refused writes left storage", d, model[8]);

    // R1 inhibited requests
    cfg_byte_cost = 4'd3; base = retry_cnt;
    issue(2'd1, 6'd48, model[12], 4'h0, 4'd4, 0, 0, acc);
    issue(2'd1, 6'd48, 32'hBAD0BAD0, 4'hF, 4'd4, 1, 1, acc);
    check(acc == 1, "R1 inhibit taken while busy", acc, 1);
    issue(2'd3, 6'd0, '0, '0, 4'd1, 0, 0, acc);
    issue(2'd1, 6'd48, 32'hBAD1BAD1, 4'hF, 4'd4, 1, 1, acc);
    check(acc == 1, "R1 inhibit taken while owed", acc, 1);
    n = 0;
    for (int i = 0; i < 20; i++) begin if (rsp_valid) n++; tick(); end
    check(n == 0, "R1 inhibit no response", n, 0);
    check(retry_cnt == base + 1, "R8 single pulse per debt", retry_cnt, base + 1);
    cfg_byte_cost = 0;
    do_read(6'd48, d, lat);
    check(d == model[12], "R1 inhibit left storage", d, model[12]);

    // R9 no response when not wanted
    issue(2'd0, 6'd4, '0, '0, 4'd4, 0, 0, acc);
    n = 0;
    for (int i = 0; i < 10; i++) begin if (rsp_valid) n++; tick(); end
    check(n == 0, "R9 no response", n, 0);

    // R3/R10 full queue, hold, order, pulse after drain
    rsp_ready = 0; base = retry_cnt;
    for (int i = 0; i < 4; i++) begin
      issue(2'd0, 6'(i*4), '0, '0, 4'd4, 1, 0, acc);
      check(acc == 1, "R10 fill queue", acc, 1);
    end
    issue(2'd0, 6'd16, '0, '0, 4'd4, 1, 0, acc);
    check(acc == 0, "R3 refused when queue full", acc, 0);
    for (int i = 0; i < 4; i++) begin
      check(rsp_valid && rsp_data == model[0], "R10 held response stable", rsp_data, model[0]);
      tick();
    end
    issue(2'd1, 6'd0, 32'hFFFFFFFF, 4'hF, 4'd4, 0, 0, acc);
    check(acc == 0, "R2 owed refuses non-response write", acc, 0);
    rsp_ready = 1;
    for (int i = 0; i < 4; i++) begin
      check(rsp_valid && rsp_data == model[i], "R10 response order", rsp_data, model[i]);
      tick();
    end
    check(rsp_valid == 0, "R3 refused read not queued", rsp_valid, 0);
    repeat (3) tick();
    check(retry_cnt == base + 1, "R8 pulse after queue drains", retry_cnt, base + 1);
    do_read(6'd0, d, lat);
    check(d == model[0], "R2 owed write left storage", d, model[0]);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule